// File: doc/BRIEF.md
# Banked Level Interrupt Controller with Shortcut Pending Word

This block collects 72 level-sensitive interrupt sources and presents them through a small word-addressed register window. There are eight local sources and two banks of 32 peripheral sources. Each source has an enable bit. Software sets enable bits through one group of mask registers and clears them through a second group. Three pending registers show only those sources that are both asserted and enabled.

The basic pending word gives software a quick first look. It holds the local sources, one summary flag for each bank, and direct copies of eleven chosen bank sources. Often one read of this word is enough to identify the source.

The block drives one combined interrupt request. Any one source may instead be routed to a separate fast-interrupt output. When it is routed, that source is removed from the combined request, and the fast output follows the source's raw level.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, all enable bits and the fast-interrupt control byte are 0, and both `irq_out` and `fiq_out` are low.
- R2: A write to byte offset 0x10 (bank 1), 0x14 (bank 2) or 0x18 (local group, data bits 7:0) sets the enable of every source whose data bit is 1. Sources whose data bit is 0 keep their enable state.
- R3: A write to byte offset 0x1C (bank 1), 0x20 (bank 2) or 0x24 (local group, bits 7:0) clears the enable of every source whose data bit is 1. Sources whose data bit is 0 keep their enable state.
- R4: Reading an enable offset or a disable offset returns the current enable bits of that group. The local group occupies bits 7:0, and bits 31:8 read 0.
- R5: Offset 0x04 reads bank 1 pending and offset 0x08 reads bank 2 pending. Bit i of each is raw source i ANDed with its enable bit.
- R6: In the basic word at offset 0x00, bits 7:0 are the local pending bits. Bit 8 is set when any bank 1 source is pending, and bit 9 is set when any bank 2 source is pending.
- R7: Basic word bits 10 to 14 copy the bank 1 pending bits 7, 9, 10, 18 and 19, in that order. Bits 15 to 20 copy the bank 2 pending bits 21, 22, 23, 24, 25 and 30, in that order. Bits 31:21 read 0.
- R8: Offset 0x0C holds a control byte that reads back in bits 7:0. Bits 6:0 select a flat source number: local 0–7, bank 1 as 8–39 (bit n−8), and bank 2 as 40–71 (bit n−40). Bit 7 turns the fast path on. While the path is on and the number is below 72, `fiq_out` equals that source's raw level, whatever its enable bit. Otherwise `fiq_out` is 0.
- R9: `irq_out` is high exactly when some source is enabled and asserted, not counting the source currently routed to the fast path.
- R10: Writes to 0x00, 0x04, 0x08 or to unmapped offsets 0x28–0x3C change no state, and unmapped offsets read 0. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_local | input | 8 | Local source levels |
| src_bank1 | input | 32 | Bank 1 source levels |
| src_bank2 | input | 32 | Bank 2 source levels |
| bus_addr | input | 6 | Byte address of register |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt request |
| fiq_out | output | 1 | Fast-interrupt request |

## Verification
Enable masks are first written in patterns that touch only the eleven shortcut sources, and then only local bits. This separates errors in shortcut bit order from errors in summary flags and local bits. Random source levels are then combined with random writes to set and clear masks. Each run of writes is followed by a read of every word offset, with nonzero low address bits, so that a mask that overwrites instead of accumulating, or a swapped register group, shows up. The fast path is routed to a local source, a bank 2 source, an out-of-range number and a disabled selector. Each case is made while that source is the only one asserted, which shows whether exclusion from `irq_out` and the raw-level follow work.

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        src_local,
  input  logic [31:0]       src_bank1,
  input  logic [31:0]       src_bank2,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out,
  output logic              fiq_out
);
  localparam int NSRC = 72;
  localparam logic [3:0] W_BASIC = 4'd0, W_PEND1 = 4'd1, W_PEND2 = 4'd2, W_FCTL = 4'd3;
  localparam logic [3:0] W_SET1 = 4'd4, W_SET2 = 4'd5, W_SETL = 4'd6;
  localparam logic [3:0] W_CLR1 = 4'd7, W_CLR2 = 4'd8, W_CLRL = 4'd9;

  logic [7:0]  en_l, fctl;
  logic [31:0] en_1, en_2;
  logic [3:0]  widx;
  logic        unused_lsb;

  assign widx       = bus_addr[5:2];
  assign unused_lsb = ^bus_addr[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_l <= '0;
      en_1 <= '0;
      en_2 <= '0;
      fctl <= '0;
    end else if (bus_wr) begin
      case (widx)
        W_FCTL: fctl <= bus_wdata[7:0];
        W_SET1: en_1 <= en_1 | bus_wdata;
        W_SET2: en_2 <= en_2 | bus_wdata;
        W_SETL: en_l <= en_l | bus_wdata[7:0];
        W_CLR1: en_1 <= en_1 & ~bus_wdata;
        W_CLR2: en_2 <= en_2 & ~bus_wdata;
        W_CLRL: en_l <= en_l & ~bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  logic [7:0]      pend_l;
  logic [31:0]     pend_1, pend_2, basic;
  logic [NSRC-1:0] raw_all, pend_all, route_mask;

  assign pend_l = src_local & en_l;
  assign pend_1 = src_bank1 & en_1;
  assign pend_2 = src_bank2 & en_2;

  assign basic = {11'b0,
                  pend_2[30], pend_2[25], pend_2[24], pend_2[23], pend_2[22], pend_2[21],
                  pend_1[19], pend_1[18], pend_1[10], pend_1[9], pend_1[7],
                  |pend_2, |pend_1, pend_l};

  assign raw_all    = {src_bank2, src_bank1, src_local};
  assign pend_all   = {pend_2, pend_1, pend_l};
  assign route_mask = fctl[7] ? (NSRC'(1) << fctl[6:0]) : '0;

  assign fiq_out = |(route_mask & raw_all);
  assign irq_out = |(pend_all & ~route_mask);

  always_comb begin
    case (widx)
      W_BASIC:        bus_rdata = basic;
      W_PEND1:        bus_rdata = pend_1;
      W_PEND2:        bus_rdata = pend_2;
      W_FCTL:         bus_rdata = {24'b0, fctl};
      W_SET1, W_CLR1: bus_rdata = en_1;
      W_SET2, W_CLR2: bus_rdata = en_2;
      W_SETL, W_CLRL: bus_rdata = {24'b0, en_l};
      default:        bus_rdata = '0;
    endcase
  end

  AST_SET_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == W_SET1) |=> ((en_1 & $past(bus_wdata)) == $past(bus_wdata))); // R2
  AST_CLR_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == W_CLRL) |=> ((en_l & $past(bus_wdata[7:0])) == 8'h00)); // R3
  AST_RO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (widx <= W_PEND2 || widx > W_CLRL)) |=>
      ($stable(en_1) && $stable(en_2) && $stable(en_l) && $stable(fctl))); // R10
  AST_FIQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out |-> (fctl[7] && fctl[6:0] < 7'd72)); // R8
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (basic[20:0] != 21'b0)); // R9
endmodule

// File: tb/sim_banked_irq_ctrl.sv
module sim_banked_irq_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [71:0] src = '0;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         irq, fiq;

  banked_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .src_local(src[7:0]), .src_bank1(src[39:8]), .src_bank2(src[71:40]),
    .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_out(irq), .fiq_out(fiq)
  );

  logic [71:0] m_en = '0;
  logic [7:0]  m_fctl = '0;
  bit          live = 1'b0;
  int          checks = 0, errors = 0;

  function automatic bit pend(int n);
    return src[n] & m_en[n];
  endfunction

  function automatic logic [31:0] exp_read(logic [5:0] a);
    int w = int'(a) / 4;
    int s1[5] = '{7, 9, 10, 18, 19};
    int s2[6] = '{21, 22, 23, 24, 25, 30};
    logic [31:0] r = '0;
    case (w)
      0: begin
        for (int i = 0; i < 8; i++) r[i] = pend(i);
        for (int i = 0; i < 32; i++) begin
          if (pend(8 + i)) r[8] = 1'b1;
          if (pend(40 + i)) r[9] = 1'b1;
        end
        for (int k = 0; k < 5; k++) r[10 + k] = pend(8 + s1[k]);
        for (int k = 0; k < 6; k++) r[15 + k] = pend(40 + s2[k]);
      end
      1: for (int i = 0; i < 32; i++) r[i] = pend(8 + i);
      2: for (int i = 0; i < 32; i++) r[i] = pend(40 + i);
      3: r[7:0] = m_fctl;
      4, 7: for (int i = 0; i < 32; i++) r[i] = m_en[8 + i];
      5, 8: for (int i = 0; i < 32; i++) r[i] = m_en[40 + i];
      6, 9: for (int i = 0; i < 8; i++) r[i] = m_en[i];
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic bit exp_irq();
    for (int n = 0; n < 72; n++)
      if (pend(n) && !(m_fctl[7] && int'(m_fctl[6:0]) == n)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit exp_fiq();
    if (!m_fctl[7] || int'(m_fctl[6:0]) >= 72) return 1'b0;
    return src[int'(m_fctl[6:0])];
  endfunction

  function automatic string tag_of(logic [5:0] a);
    case (int'(a) / 4)
      0: return "R6 R7";
      1, 2: return "R5";
      3: return "R8";
      4, 5, 6: return "R2 R4";
      7, 8, 9: return "R3 R4";
      default: return "R10";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (live) begin
    #3;
    check(rdata == exp_read(addr), tag_of(addr), rdata, exp_read(addr));
    check(irq == exp_irq(), "R9", {31'b0, irq}, {31'b0, exp_irq()});
    check(fiq == exp_fiq(), "R8", {31'b0, fiq}, {31'b0, exp_fiq()});
  end

  task automatic wr_reg(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wr = 1'b1; wdata = d;
    @(posedge clk);
    case (int'(a) / 4)
      3: m_fctl = d[7:0];
      4: m_en[39:8]  = m_en[39:8]  | d;
      5: m_en[71:40] = m_en[71:40] | d;
      6: m_en[7:0]   = m_en[7:0]   | d[7:0];
      7: m_en[39:8]  = m_en[39:8]  & ~d;
      8: m_en[71:40] = m_en[71:40] & ~d;
      9: m_en[7:0]   = m_en[7:0]   & ~d[7:0];
      default: ;
    endcase
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic sweep();
    for (int w = 0; w < 16; w++) begin
      @(negedge clk);
      addr = 6'(w * 4 + (w % 4));
    end
  endtask

  task automatic set_src(logic [71:0] v);
    @(negedge clk);
    src = v;
  endtask

  task automatic do_reset();
    live = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    m_en = '0; m_fctl = '0;
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    check(irq == 1'b0 && fiq == 1'b0, "R1", {30'b0, irq, fiq}, 32'h0);
    live = 1'b1;
  endtask

  function automatic logic [71:0] rnd72();
    logic [71:0] v;
    v[31:0]  = $urandom();
    v[63:32] = $urandom();
    v[71:64] = 8'($urandom());
    return v;
  endfunction

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL R1: watchdog expired, actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    src = '1;
    repeat (3) @(posedge clk);
    do_reset();
    sweep();
    wr_reg(6'h10, 32'h000C0680);
    sweep();
    wr_reg(6'h14, 32'h43E00000);
    sweep();
    wr_reg(6'h18, 32'hFFFFFF0F);
    sweep();
    wr_reg(6'h1C, 32'h00000080);
    wr_reg(6'h24, 32'h00000003);
    sweep();
    for (int it = 0; it < 40; it++) begin
      logic [5:0] a;
      set_src(rnd72());
      a = 6'(16 + 4 * ($urandom() % 6));
      wr_reg(a, $urandom());
      if (it % 4 == 0) sweep();
    end
    wr_reg(6'h10, '1); wr_reg(6'h14, '1); wr_reg(6'h18, '1);
    set_src(72'h8);
    wr_reg(6'h0C, 32'h83);
    sweep();
    set_src(72'h0);
    sweep();
    set_src(72'h1 << 45);
    wr_reg(6'h0C, 32'h80 | 32'd45);
    sweep();
    wr_reg(6'h2C, 32'hFF);
    wr_reg(6'h0C, 32'hC8);
    sweep();
    wr_reg(6'h0C, 32'h2D);
    sweep();
    set_src(rnd72());
    wr_reg(6'h0C, 32'h80 | 32'd71);
    sweep();
    wr_reg(6'h00, '1); wr_reg(6'h04, '1); wr_reg(6'h08, '1);
    wr_reg(6'h28, '1); wr_reg(6'h3C, '1); wr_reg(6'h1C, '0);
    sweep();
    wr_reg(6'h20, '1);
    sweep();
    do_reset();
    set_src('1);
    sweep();
    live = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule